// File: doc/BRIEF.md
# Two-Write Two-Read Replicated Memory

This block is a memory that accepts two independent writes and two independent reads in every clock cycle, without a faster internal clock. Storage is split into four simple dual-port banks, one for each pairing of a write port with a read port. Each write port copies its data into the two banks it owns, one bank per read port.

Each read port fetches its address from two banks, one filled by each write port. A small live-value tracker keeps one mark bit per address for each write port. Comparing the two marks tells which write port wrote that address last. The read port then keeps that port's copy and discards the other.

Reads are synchronous and take one cycle. A read that hits an address being written in the same cycle returns the previous contents. The two write ports must never target the same address in the same cycle. The price of this scheme is four times the bank storage of a single dual-port array.

Top module: `dual_wr_mem`

## Requirements
- R1: The data for an address presented on a read port at a rising clock edge is on that port's data output after the next rising edge, and stays there until the edge after that.
- R2: A write accepted on write port 0 is returned by both read ports when either reads that address one cycle later.
- R3: A write accepted on write port 1 is returned by both read ports when either reads that address one cycle later.
- R4: When the two write ports write the same address in different cycles, both read ports return the value of the later write. This holds in either order and across repeated alternation.
- R5: In one cycle, both write ports may write two distinct addresses while both read ports read any addresses, and all four operations take effect. Both write ports enabled on the same address in the same cycle is a usage error and is flagged.
- R6: A read and a write to the same address in the same cycle return the contents from before that write (read-before-write). The new value is returned from the following cycle on.
- R7: A write port whose enable is low changes no stored data, whatever its address and data inputs carry.
- R8: While the active-low asynchronous reset is asserted, both read data outputs are zero.
- R9: Under mixed random traffic on all four ports, with distinct write addresses in each cycle, every read matches a reference array updated in read-before-write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W | Write port 0 address |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | ADDR_W | Write port 1 address |
| wr1_data | input | DATA_W | Write port 1 data |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 data, one cycle after the address |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 data, one cycle after the address |

## Verification
Every read result is due exactly one rising edge after its address is sampled. A write becomes readable at the edge that captures it, so a read sampled in the next cycle already returns it. A same-cycle read still returns the older value.

Each bench cycle drives all inputs on a falling edge. It records the expected read values from the reference array before applying that cycle's writes. It then compares both outputs on the following falling edge, which is half a period after the register that produces them has updated.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

  // Which write port's copy a reader must keep.
  typedef enum logic {
    SRC_PORT0 = 1'b0,
    SRC_PORT1 = 1'b1
  } src_e;

  // Equal marks: port 0 wrote last. Different marks: port 1 wrote last.
  function automatic src_e pick_source(input logic mark0, input logic mark1);
    return (mark0 == mark1) ? SRC_PORT0 : SRC_PORT1;
  endfunction

endpackage

// File: rtl/dwm_bank.sv
module dwm_bank #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_nxt;

  // Storage: write gated by its enable, no reset on the array.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Old contents are read before this edge's write lands.
  always_comb begin
    rdata_nxt = store[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_nxt;
    end
  end

endmodule

// File: rtl/dwm_tracker.sv
module dwm_tracker
  import dwm_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9,
  parameter int N_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w0_en,
  input  logic [ADDR_W-1:0] w0_addr,
  input  logic              w1_en,
  input  logic [ADDR_W-1:0] w1_addr,
  input  logic [ADDR_W-1:0] r_addr [N_RD],
  output src_e              r_src  [N_RD]
);

  // One mark bit per address for each write port.
  logic mark0 [DEPTH];
  logic mark1 [DEPTH];
  logic mark0_nxt;
  logic mark1_nxt;

  // Port 0 copies the other mark, port 1 stores its inverse.
  always_comb begin
    mark0_nxt = mark1[w0_addr];
    mark1_nxt = ~mark0[w1_addr];
  end

  always_ff @(posedge clk) begin
    if (w0_en) begin
      mark0[w0_addr] <= mark0_nxt;
    end
    if (w1_en) begin
      mark1[w1_addr] <= mark1_nxt;
    end
  end

  // Per-reader select, registered to line up with the bank outputs.
  for (genvar r = 0; r < N_RD; r++) begin : g_sel
    src_e src_nxt;

    always_comb begin
      src_nxt = pick_source(mark0[r_addr[r]], mark1[r_addr[r]]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_src[r] <= SRC_PORT0;
      end else begin
        r_src[r] <= src_nxt;
      end
    end
  end

endmodule

// File: rtl/dual_wr_mem.sv
module dual_wr_mem
  import dwm_pkg::*;
#(
  parameter int  DEPTH  = 512,
  parameter int  DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);

  localparam int N_WR = 2;
  localparam int N_RD = 2;

  logic              w_en   [N_WR];
  logic [ADDR_W-1:0] w_addr [N_WR];
  logic [DATA_W-1:0] w_data [N_WR];
  logic [ADDR_W-1:0] r_addr [N_RD];
  logic [DATA_W-1:0] r_data [N_RD];
  logic [DATA_W-1:0] bank_q [N_WR][N_RD];
  src_e              r_src  [N_RD];

  always_comb begin
    w_en[0]   = wr0_en;
    w_addr[0] = wr0_addr;
    w_data[0] = wr0_data;
    w_en[1]   = wr1_en;
    w_addr[1] = wr1_addr;
    w_data[1] = wr1_data;
    r_addr[0] = rd0_addr;
    r_addr[1] = rd1_addr;
  end

  // One bank per (write port, read port) pair.
  for (genvar w = 0; w < N_WR; w++) begin : g_wr
    for (genvar r = 0; r < N_RD; r++) begin : g_rd
      dwm_bank #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
      ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (w_en[w]),
        .waddr(w_addr[w]),
        .wdata(w_data[w]),
        .raddr(r_addr[r]),
        .rdata(bank_q[w][r])
      );
    end
  end

  dwm_tracker #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .N_RD  (N_RD)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .w0_en  (wr0_en),
    .w0_addr(wr0_addr),
    .w1_en  (wr1_en),
    .w1_addr(wr1_addr),
    .r_addr (r_addr),
    .r_src  (r_src)
  );

  // Each reader keeps the copy from the port that wrote last.
  for (genvar r = 0; r < N_RD; r++) begin : g_mux
    always_comb begin
      r_data[r] = (r_src[r] == SRC_PORT1) ? bank_q[1][r] : bank_q[0][r];
    end
  end

  assign rd0_data = r_data[0];
  assign rd1_data = r_data[1];

endmodule

// File: rtl/dual_wr_mem_chk.sv
module dual_wr_mem_chk #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr0_en,
  input logic [ADDR_W-1:0] wr0_addr,
  input logic [DATA_W-1:0] wr0_data,
  input logic              wr1_en,
  input logic [ADDR_W-1:0] wr1_addr,
  input logic [DATA_W-1:0] wr1_data,
  input logic [ADDR_W-1:0] rd0_addr,
  input logic [DATA_W-1:0] rd0_data,
  input logic [ADDR_W-1:0] rd1_addr,
  input logic [DATA_W-1:0] rd1_data
);

  // Cycles since reset release, saturating; gates every $past lookup.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  assert_distinct_write_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr1_en) |-> (wr0_addr != wr1_addr));

  assert_port0_to_rd0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(wr0_en) && rd0_addr == $past(wr0_addr))
      |=> rd0_data == $past(wr0_data, 2));

  assert_port0_to_rd1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(wr0_en) && rd1_addr == $past(wr0_addr))
      |=> rd1_data == $past(wr0_data, 2));

  assert_port1_to_rd0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(wr1_en) && rd0_addr == $past(wr1_addr))
      |=> rd0_data == $past(wr1_data, 2));

  assert_port1_to_rd1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(wr1_en) && rd1_addr == $past(wr1_addr))
      |=> rd1_data == $past(wr1_data, 2));

  always_comb begin
    if (rst_n == 1'b0) begin
      assert_reset_zero_R8: assert (rd0_data == '0 && rd1_data == '0);
    end
  end

endmodule

bind dual_wr_mem dual_wr_mem_chk #(
  .DEPTH (DEPTH),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr0_en  (wr0_en),
  .wr0_addr(wr0_addr),
  .wr0_data(wr0_data),
  .wr1_en  (wr1_en),
  .wr1_addr(wr1_addr),
  .wr1_data(wr1_data),
  .rd0_addr(rd0_addr),
  .rd0_data(rd0_data),
  .rd1_addr(rd1_addr),
  .rd1_data(rd1_data)
);

// File: tb/dual_wr_mem_test.sv
`timescale 1ns/1ps
module dual_wr_mem_test;

  localparam int DEPTH = 512;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk;
  logic          rst_n;
  logic          wr0_en, wr1_en;
  logic [AW-1:0] wr0_addr, wr1_addr, rd0_addr, rd1_addr;
  logic [DW-1:0] wr0_data, wr1_data, rd0_data, rd1_data;

  int checks;
  int failures;
  bit done;
  logic [DW-1:0] ref_mem [DEPTH];

  dual_wr_mem #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle on a falling edge, update the reference in
  // read-before-write order, then compare on the next falling edge.
  task automatic cyc(input bit e0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                     input bit e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                     input logic [AW-1:0] ra0, input logic [AW-1:0] ra1,
                     input bit chk, input string tag);
    logic [DW-1:0] exp0, exp1;
    wr0_en = e0; wr0_addr = a0; wr0_data = d0;
    wr1_en = e1; wr1_addr = a1; wr1_data = d1;
    rd0_addr = ra0; rd1_addr = ra1;
    exp0 = ref_mem[ra0];
    exp1 = ref_mem[ra1];
    if (e0) ref_mem[a0] = d0;
    if (e1) ref_mem[a1] = d1;
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      check({tag, " rd0"}, rd0_data, exp0);
      check({tag, " rd1"}, rd1_data, exp1);
    end
  endtask

  task automatic t_reset_R8();
    rst_n = 1'b0;
    wr0_en = 1'b0; wr1_en = 1'b0;
    wr0_addr = '0; wr1_addr = '0; wr0_data = '0; wr1_data = '0;
    rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(negedge clk);
    check("R8 rd0 in reset", rd0_data, '0);
    check("R8 rd1 in reset", rd1_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH / 2; i++) begin
      cyc(1'b1, AW'(2 * i), DW'(32'h1000_0000 + 2 * i),
          1'b1, AW'(2 * i + 1), DW'(32'h2000_0000 + 2 * i + 1),
          '0, '0, 1'b0, "fill");
    end
  endtask

  task automatic t_port0_R2();
    cyc(1'b1, AW'(10), 32'hA0A0_0010, 1'b0, '0, '0, AW'(3), AW'(4), 1'b0, "R2");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(10), AW'(10), 1'b1, "R2 R1 port0 write");
    check("R2 rd0 constant", rd0_data, 32'hA0A0_0010);
    check("R2 rd1 constant", rd1_data, 32'hA0A0_0010);
  endtask

  task automatic t_port1_R3();
    cyc(1'b0, '0, '0, 1'b1, AW'(21), 32'hB1B1_0021, AW'(0), AW'(1), 1'b0, "R3");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(21), AW'(21), 1'b1, "R3 port1 write");
    check("R3 rd0 constant", rd0_data, 32'hB1B1_0021);
  endtask

  task automatic t_hold_R1();
    // Address changes every cycle; each result shows up one edge later.
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(40 + i), AW'(300 - i), 1'b1, "R1 streaming reads");
    end
  endtask

  task automatic t_override_R4();
    cyc(1'b1, AW'(5), 32'h0000_AAAA, 1'b0, '0, '0, '0, '0, 1'b0, "R4");
    cyc(1'b0, '0, '0, 1'b1, AW'(5), 32'h0000_BBBB, '0, '0, 1'b0, "R4");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(5), AW'(5), 1'b1, "R4 port1 later");
    check("R4 rd0 constant B", rd0_data, 32'h0000_BBBB);
    cyc(1'b1, AW'(5), 32'h0000_CCCC, 1'b0, '0, '0, '0, '0, 1'b0, "R4");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(5), AW'(5), 1'b1, "R4 port0 later");
    check("R4 rd1 constant C", rd1_data, 32'h0000_CCCC);
    for (int i = 0; i < 6; i++) begin
      cyc(i % 2 == 0, AW'(6), DW'(32'hD000 + i), i % 2 == 1, AW'(6), DW'(32'hE000 + i),
          AW'(6), AW'(6), 1'b1, "R4 alternating");
    end
  endtask

  task automatic t_parallel_R5();
    cyc(1'b1, AW'(100), 32'h5555_0100, 1'b1, AW'(101), 32'h5555_0101,
        AW'(200), AW'(201), 1'b1, "R5 four ops");
    cyc(1'b1, AW'(102), 32'h5555_0102, 1'b1, AW'(103), 32'h5555_0103,
        AW'(100), AW'(101), 1'b1, "R5 read back");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(102), AW'(103), 1'b1, "R5 read back 2");
    check("R5 rd0 constant", rd0_data, 32'h5555_0102);
  endtask

  task automatic t_rbw_R6();
    cyc(1'b1, AW'(7), 32'h7777_0007, 1'b1, AW'(8), 32'h8888_0008,
        AW'(7), AW'(8), 1'b1, "R6 same-cycle read old");
    check("R6 rd0 not new", rd0_data == 32'h7777_0007 ? 32'h1 : 32'h0, 32'h0);
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(7), AW'(8), 1'b1, "R6 next cycle new");
    check("R6 rd1 constant", rd1_data, 32'h8888_0008);
  endtask

  task automatic t_disabled_R7();
    cyc(1'b0, AW'(9), 32'hDEAD_0009, 1'b0, AW'(11), 32'hDEAD_0011, '0, '0, 1'b0, "R7");
    cyc(1'b0, '0, '0, 1'b0, '0, '0, AW'(9), AW'(11), 1'b1, "R7 enable low no change");
    check("R7 rd0 constant fill", rd0_data, 32'h2000_0009);
  endtask

  task automatic t_random_R9();
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a0, a1;
      a0 = AW'($urandom);
      a1 = AW'($urandom);
      if (a1 == a0) a1 = a0 + 1'b1;
      cyc(bit'($urandom), a0, DW'($urandom), bit'($urandom), a1, DW'($urandom),
          AW'($urandom), ($urandom % 4 == 0) ? a0 : AW'($urandom), 1'b1, "R9 random");
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    t_reset_R8();
    t_fill();
    t_port0_R2();
    t_port1_R3();
    t_hold_R1();
    t_override_R4();
    t_parallel_R5();
    t_rbw_R6();
    t_disabled_R7();
    t_random_R9();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule